// File: doc/BRIEF.md
# Write-Masked Control Register Bank

This block holds seven 32-bit configuration words and one read-only status word behind a plain memory-mapped strobe interface. A write never needs a prior read: the upper half of each written word acts as a per-bit enable for the lower half. A lower bit changes only where its partner enable bit is set, so one software agent can flip a single control field while leaving the neighbouring fields untouched.

The last control word (byte offset 0x18) drives two pins of a power sequencing controller. Its bit 0 is an active-high power enable and its bit 1 enables the delay-locked loop. The status word at offset 0x20 reflects two progress flags coming back from that controller. These are calibration complete and DLL locked.

The bus has no handshake and no back-pressure. A write takes effect at the clock edge on which the write strobe is high. Read data is captured at the clock edge on which the read strobe is high and holds until the next read.

Top module: `cfgmask_bank`

## Requirements
- R1: Reset (active-low `rst_n`) clears all seven control words, the read data register and both control outputs to zero.
- R2: On a write to a control word, lower bit x takes `wr_data[x]` when `wr_data[x+16]` is 1; where that enable bit is 0 the stored bit keeps its old value.
- R3: The control words sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. Each is independent of the others. A read returns the stored 16 bits in `rd_data[15:0]` and zero in `rd_data[31:16]`.
- R4: A read of offset 0x20 returns `cal_done_i` in bit 6, `dll_locked_i` in bit 5 and zero in every other bit. Writes to 0x20 change nothing.
- R5: Offset 0x1C, every offset above 0x20, and any address whose two low bits are not zero map to nothing. A write there changes nothing, and a read there returns zero.
- R6: `pwr_en_o` equals bit 0 and `dll_en_o` equals bit 1 of the word at 0x18. Both are visible from the clock edge that performs the write.
- R7: `rd_data` is loaded at the clock edge where `rd_stb` is high and keeps its value at every other edge.
- R8: When a read and a write to the same word fall in one cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Byte address, word aligned |
| wr_data | input | 32 | Enables in [31:16], data in [15:0] |
| rd_data | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration complete flag |
| dll_locked_i | input | 1 | DLL locked flag |
| pwr_en_o | output | 1 | Power enable to the sequencer |
| dll_en_o | output | 1 | DLL enable to the sequencer |

## Verification
A read and a masked write can hit the same word in one cycle. The bench provokes this by raising both strobes together on offset 0x08 while the word holds a known value. It judges the result in two steps. The read data captured at that edge must be the old value, and a following plain read must return the newly merged value. A table of masked writes and reads covers partial, empty and full enable masks, the status word and the unmapped holes. Directed steps then drive the power and DLL pins one field at a time.

// File: rtl/cfgmask_pkg.sv
package cfgmask_pkg;
  localparam int WORD_W    = 32;
  localparam int HALF_W    = WORD_W / 2;
  localparam int NUM_CTRL  = 7;
  localparam int STAT_IDX  = 8;   // word index of the status word (byte 0x20)
  localparam int SEQ_IDX   = 6;   // word index feeding the sequencer (byte 0x18)
  localparam int PWR_BIT   = 0;
  localparam int DLLEN_BIT = 1;
  localparam int CAL_BIT   = 6;
  localparam int LOCK_BIT  = 5;
endpackage

// File: rtl/cfgmask_decode.sv
module cfgmask_decode #(
  parameter int ADDR_W = 8,
  parameter int NCTRL  = cfgmask_pkg::NUM_CTRL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCTRL-1:0]  ctrl_sel,
  output logic              stat_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NCTRL; i++) begin : g_sel
    assign ctrl_sel[i] = aligned && (word_idx == IDX_W'(i));
  end

  assign stat_sel = aligned && (word_idx == IDX_W'(cfgmask_pkg::STAT_IDX));

  // R5: at most one target is ever selected
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_sel, stat_sel}));
endmodule

// File: rtl/cfgmask_word.sv
module cfgmask_word #(
  parameter int WW = cfgmask_pkg::WORD_W,
  localparam int HW = WW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [WW-1:0] wdata,
  output logic [HW-1:0] q
);
  logic [HW-1:0] en_bits;
  logic [HW-1:0] new_bits;

  assign en_bits  = wdata[WW-1:HW];
  assign new_bits = wdata[HW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= (q & ~en_bits) | (new_bits & en_bits);
  end

  // R2: without a write the word does not move
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  // R2: bits whose enable was clear never change on a write
  a_r2_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(q)) & ~$past(en_bits)) == '0));
endmodule

// File: rtl/cfgmask_rdmux.sv
module cfgmask_rdmux #(
  parameter int NCTRL = cfgmask_pkg::NUM_CTRL,
  parameter int WW    = cfgmask_pkg::WORD_W,
  localparam int HW   = WW / 2
) (
  input  logic [NCTRL*HW-1:0] ctrl_flat,
  input  logic [NCTRL-1:0]    ctrl_sel,
  input  logic                stat_sel,
  input  logic                cal_done,
  input  logic                dll_locked,
  output logic [WW-1:0]       rd_val
);
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCTRL; i++) begin
      if (ctrl_sel[i]) rd_val[HW-1:0] = ctrl_flat[i*HW +: HW];
    end
    if (stat_sel) begin
      rd_val[cfgmask_pkg::CAL_BIT]  = cal_done;
      rd_val[cfgmask_pkg::LOCK_BIT] = dll_locked;
    end
  end
endmodule

// File: rtl/cfgmask_bank.sv
module cfgmask_bank #(
  parameter int ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic        rd_stb,
  input  logic [7:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        cal_done_i,
  input  logic        dll_locked_i,
  output logic        pwr_en_o,
  output logic        dll_en_o
);
  import cfgmask_pkg::*;

  localparam int NC = NUM_CTRL;
  localparam int HW = HALF_W;

  logic [NC-1:0]    ctrl_sel;
  logic             stat_sel;
  logic [NC*HW-1:0] ctrl_flat;
  logic [WORD_W-1:0] rd_val;
  logic [HW-1:0]    seq_word;

  cfgmask_decode #(.ADDR_W(ADDR_W), .NCTRL(NC)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr[ADDR_W-1:0]),
    .ctrl_sel (ctrl_sel),
    .stat_sel (stat_sel)
  );

  for (genvar i = 0; i < NC; i++) begin : g_word
    cfgmask_word #(.WW(WORD_W)) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_stb && ctrl_sel[i]),
      .wdata (wr_data),
      .q     (ctrl_flat[i*HW +: HW])
    );
  end

  cfgmask_rdmux #(.NCTRL(NC), .WW(WORD_W)) u_mux (
    .ctrl_flat  (ctrl_flat),
    .ctrl_sel   (ctrl_sel),
    .stat_sel   (stat_sel),
    .cal_done   (cal_done_i),
    .dll_locked (dll_locked_i),
    .rd_val     (rd_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= rd_val;
  end

  assign seq_word = ctrl_flat[SEQ_IDX*HW +: HW];
  assign pwr_en_o = seq_word[PWR_BIT];
  assign dll_en_o = seq_word[DLLEN_BIT];

  // R7: read data only moves on a read strobe
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
  // R3: enable half of a control word never reads back
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (|ctrl_sel)) |=> (rd_data[31:16] == 16'h0));
  // R5: holes read as zero
  a_r5_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(|ctrl_sel) && !stat_sel) |=> (rd_data == 32'h0));
  // R4: only the two flag bits of the status word can be set
  a_r4_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && stat_sel) |=> ((rd_data & ~32'h0000_0060) == 32'h0));
  // R6: sequencer pins change only through a write
  a_r6_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(pwr_en_o) && $stable(dll_en_o)));
endmodule

// File: tb/cfgmask_bank_tb.sv
module cfgmask_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic        rd_stb = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cal_done_i = 1'b0;
  logic        dll_locked_i = 1'b0;
  logic        pwr_en_o;
  logic        dll_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cfgmask_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .cal_done_i(cal_done_i), .dll_locked_i(dll_locked_i),
    .pwr_en_o(pwr_en_o), .dll_en_o(dll_en_o)
  );

  // {req[3:0], is_read, addr[7:0], wdata[31:0], expected[31:0]}
  localparam int NV = 18;
  localparam logic [76:0] VEC [NV] = '{
    {4'd2, 1'b0, 8'h00, 32'hFFFF_1234, 32'h0},
    {4'd2, 1'b1, 8'h00, 32'h0,         32'h0000_1234},
    {4'd2, 1'b0, 8'h00, 32'h00F0_ABCD, 32'h0},
    {4'd2, 1'b1, 8'h00, 32'h0,         32'h0000_12C4},
    {4'd2, 1'b0, 8'h04, 32'h0000_FFFF, 32'h0},
    {4'd2, 1'b1, 8'h04, 32'h0,         32'h0000_0000},
    {4'd6, 1'b0, 8'h18, 32'h0001_0001, 32'h0},
    {4'd6, 1'b1, 8'h18, 32'h0,         32'h0000_0001},
    {4'd5, 1'b0, 8'h1C, 32'hFFFF_FFFF, 32'h0},
    {4'd5, 1'b1, 8'h1C, 32'h0,         32'h0000_0000},
    {4'd4, 1'b0, 8'h20, 32'hFFFF_FFFF, 32'h0},
    {4'd4, 1'b1, 8'h20, 32'h0,         32'h0000_0040},
    {4'd3, 1'b0, 8'h14, 32'hFFFF_5A5A, 32'h0},
    {4'd3, 1'b1, 8'h14, 32'h0,         32'h0000_5A5A},
    {4'd3, 1'b1, 8'h00, 32'h0,         32'h0000_12C4},
    {4'd5, 1'b1, 8'h40, 32'h0,         32'h0000_0000},
    {4'd2, 1'b0, 8'h09, 32'hFFFF_FFFF, 32'h0},
    {4'd3, 1'b1, 8'h08, 32'h0,         32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 pins", {30'h0, dll_en_o, pwr_en_o}, 32'h0);
    rst_n = 1'b1;
    cal_done_i = 1'b1;

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][72]) begin
        do_read(VEC[k][71:64], v);
        check($sformatf("R%0d vec %0d", VEC[k][76:73], k), v, VEC[k][31:0]);
      end else begin
        do_write(VEC[k][71:64], VEC[k][63:32]);
      end
    end

    // R6: DLL enable set alone, power enable kept
    do_write(8'h18, 32'h0002_0002);
    check("R6 dll on", {30'h0, dll_en_o, pwr_en_o}, 32'h3);
    do_write(8'h18, 32'h0001_0000);
    check("R6 pwr off", {30'h0, dll_en_o, pwr_en_o}, 32'h2);

    // R4: status flags swapped
    cal_done_i = 1'b0; dll_locked_i = 1'b1;
    do_read(8'h20, v);
    check("R4 lock only", v, 32'h0000_0020);

    // R7: write without read leaves rd_data
    do_write(8'h20, 32'hFFFF_FFFF);
    do_write(8'h0C, 32'hFFFF_7777);
    check("R7 hold", rd_data, 32'h0000_0020);

    // R8: simultaneous read and write on 0x08
    do_write(8'h08, 32'hFF00_8899);
    @(negedge clk);
    addr = 8'h08; wr_data = 32'hFFFF_0011; wr_stb = 1'b1; rd_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    check("R8 old value", rd_data, 32'h0000_8800);
    do_read(8'h08, v);
    check("R8 new value", v, 32'h0000_0011);
    do_read(8'h0C, v);
    check("R3 word 0x0C", v, 32'h0000_7777);

    // R1: reset in mid run clears words and pins
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 pins mid", {30'h0, dll_en_o, pwr_en_o}, 32'h0);
    rst_n = 1'b1;
    do_read(8'h14, v);
    check("R1 word cleared", v, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule